// File: doc/BRIEF.md
# Cascaded Seven-Channel DMA Controller

This block arbitrates among seven direct-memory-access channels arranged as two cascaded groups. The primary group holds channels 0 to 3. The secondary group holds channels 5 to 7. Channel 4 is the internal link through which the whole secondary group competes for service as one slot of the primary group. Each channel keeps a 27-bit current address and a current transfer count. It takes a request either from a hardware request line or from a software request bit. When a channel is granted, its acknowledge line is raised and the transfer address is presented to an external cycle sequencer. The sequencer runs the bus cycle and pulses a done input when it finishes.

Channels 0 to 3 move bytes and step their address by one byte. Channels 5 to 7 move 16-bit words. For these, the stored address counts words and is shifted left one bit to give the byte address. Each transfer uses one count. The transfer made when the count is already zero carries the terminal-count flag. After that transfer the channel halts until software rewrites its address or its count. A single register write port sets addresses, counts, software requests and the priority mode. Only single transfers are supported.

Top module: `dma7_ctrl`

## Requirements
- R1: After reset, `dack`, `xfer_valid`, `xfer_word` and `xfer_tc` are all 0, and fixed priority is selected.
- R2: Under fixed priority, the lower channel number wins within each group, and any of channels 0–3 beats the whole secondary group (channels 5–7).
- R3: With `reg_sel`=3 and `reg_data[0]`=1 (rotating priority), the slot just served becomes lowest within its group. When a secondary channel is served, the link slot also becomes lowest in the primary group.
- R4: Writing `reg_sel`=2 with `reg_data[0]`=1 sets the software request of channel `reg_chan`, which then requests exactly like its hardware line. The bit clears when that channel performs its terminal-count transfer.
- R5: For channels 0–3, `xfer_addr` equals the current address, `xfer_word` is 0, and each completed transfer adds 1 to the address.
- R6: For channels 5–7, `xfer_addr` is the current word address shifted left one bit (bit 0 is 0), `xfer_word` is 1, and each completed transfer adds 1 word (2 bytes).
- R7: Each completed transfer decrements the count. The transfer started with a count of 0 shows `xfer_tc`=1. The channel then ignores all requests until its address (`reg_sel`=0) or count (`reg_sel`=1) is rewritten.
- R8: At most one `dack` bit is high. The grant appears on the clock edge after a request is seen while idle, stays unchanged until `seq_done`, and drops on the edge that samples `seq_done`.
- R9: Channel 4 is never acknowledged. Its register writes and `dreq[4]` have no effect.
- R10: From reset, every channel ignores hardware and software requests until its address or count is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 address, 1 count, 2 software request, 3 priority mode |
| reg_chan | input | 3 | Target channel of the write |
| reg_data | input | 27 | Write data |
| dreq | input | 8 | Hardware request per channel (bit 4 unused) |
| seq_done | input | 1 | Cycle sequencer finished the current transfer |
| dack | output | 8 | One-hot acknowledge of the channel being served |
| xfer_valid | output | 1 | A transfer is in progress |
| xfer_addr | output | 27 | Byte address of the current transfer |
| xfer_word | output | 1 | Current transfer is 16 bits wide |
| xfer_tc | output | 1 | Current transfer is the terminal-count transfer |

## Verification
The embedded properties check the acknowledge handshake on every cycle. They confirm that `dack` is never more than one-hot, is never raised for the link channel, holds steady until `seq_done` and drops right after it. They also confirm that word transfers always present an even byte address, that the fixed-priority winner has no lower requester, and that a channel halts and drops its software request after terminal count. The bench scenarios are needed for the actual grant orders under fixed and rotating priority, for address stepping and count exhaustion over several transfers, and for re-arming by a register write. They also cover the inert state after reset and the discarding of channel-4 writes, which can only be seen from a run of several transfers.

// File: rtl/dma7_pkg.sv
package dma7_pkg;
    localparam int NUM_CH  = 8;
    localparam int LINK_CH = 4;
    localparam int ADDR_W  = 27;
    localparam int CNT_W   = 16;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_SWREQ = 2'd2,
        SEL_MODE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } ctl_state_e;

    // Word-wide channels sit above the link channel.
    function automatic logic chan_is_word(input int ch, input int link);
        return ch > link;
    endfunction

    // Word channels store a word address; the byte address is one bit up.
    function automatic logic [ADDR_W-1:0] byte_view(input logic [ADDR_W-1:0] a,
                                                    input logic word);
        return word ? {a[ADDR_W-2:0], 1'b0} : a;
    endfunction
endpackage

// File: rtl/dma7_chan.sv
module dma7_chan
    import dma7_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int CW   = CNT_W,
    parameter bit WORD = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_addr,
    input  logic          wr_count,
    input  logic          wr_swreq,
    input  logic [AW-1:0] wr_data,
    input  logic          hw_req,
    input  logic          step,
    output logic          req,
    output logic [AW-1:0] out_addr,
    output logic          at_last
);
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_cnt;
    logic          sw_req;
    logic          halted;

    assign at_last  = (cur_cnt == '0);
    assign req      = (hw_req | sw_req) & ~halted;
    assign out_addr = byte_view(cur_addr, WORD);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
            sw_req   <= 1'b0;
            halted   <= 1'b1;
        end else begin
            if (step) begin
                cur_addr <= cur_addr + 1'b1;
                cur_cnt  <= cur_cnt - 1'b1;
                if (at_last) begin
                    halted <= 1'b1;
                    sw_req <= 1'b0;
                end
            end
            // Register writes take precedence over a coincident step.
            if (wr_addr) begin
                cur_addr <= wr_data;
                halted   <= 1'b0;
            end
            if (wr_count) begin
                cur_cnt <= wr_data[CW-1:0];
                halted  <= 1'b0;
            end
            if (wr_swreq) begin
                sw_req <= wr_data[0];
            end
        end
    end

    // R7: the terminal transfer leaves the channel silent
    a_r7_halt_after_last: assert property (@(posedge clk) disable iff (rst)
        (step && at_last && !wr_addr && !wr_count) |=> !req);

    // R4: the terminal transfer drops the software request
    a_r4_sw_cleared: assert property (@(posedge clk) disable iff (rst)
        (step && at_last && !wr_swreq) |=> !sw_req);
endmodule

// File: rtl/dma7_arb.sv
module dma7_arb #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          rotate,
    input  logic          take,
    output logic          any,
    output logic [IW-1:0] win
);
    logic [IW-1:0] last;
    int            start;
    int            idx;

    always_comb begin
        start = 0;
        if (rotate) begin
            start = (int'(last) == N - 1) ? 0 : int'(last) + 1;
        end
        any = 1'b0;
        win = '0;
        idx = 0;
        for (int k = 0; k < N; k++) begin
            idx = start + k;
            if (idx >= N) idx = idx - N;
            if (!any && req[idx]) begin
                any = 1'b1;
                win = idx[IW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last <= IW'(N - 1);
        end else if (take) begin
            last <= win;
        end
    end

    // R2: with fixed order no lower slot is left waiting
    a_r2_fixed_lowest: assert property (@(posedge clk) disable iff (rst)
        (!rotate && any) |-> ((req & ~({N{1'b1}} << win)) == '0));

    // R3: rotating order never skips to a slot that is not requesting
    a_r3_winner_requests: assert property (@(posedge clk) disable iff (rst)
        any |-> req[win]);
endmodule

// File: rtl/dma7_ctrl.sv
module dma7_ctrl
    import dma7_pkg::*;
#(
    parameter int CH_N  = NUM_CH,
    parameter int LINK  = LINK_CH,
    parameter int AW    = ADDR_W,
    parameter int CW    = CNT_W,
    localparam int CHW   = $clog2(CH_N),
    localparam int PRI_N = LINK + 1,
    localparam int SEC_N = CH_N - LINK - 1,
    localparam int PW    = $clog2(PRI_N),
    localparam int SW    = (SEC_N > 1) ? $clog2(SEC_N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic [1:0]      reg_sel,
    input  logic [CHW-1:0]  reg_chan,
    input  logic [AW-1:0]   reg_data,
    input  logic [CH_N-1:0] dreq,
    input  logic            seq_done,
    output logic [CH_N-1:0] dack,
    output logic            xfer_valid,
    output logic [AW-1:0]   xfer_addr,
    output logic            xfer_word,
    output logic            xfer_tc
);
    localparam logic [PW-1:0] LINK_SLOT = PW'(LINK);

    ctl_state_e     state;
    logic [CHW-1:0] cur_ch;
    logic           rotate;

    logic [CH_N-1:0] ch_req;
    logic [CH_N-1:0] ch_last;
    logic [CH_N-1:0] ch_step;
    logic [AW-1:0]   ch_addr [CH_N];

    logic [PRI_N-1:0] pri_req;
    logic [SEC_N-1:0] sec_req;
    logic             pri_any, sec_any;
    logic [PW-1:0]    pri_win;
    logic [SW-1:0]    sec_win;
    logic             grant, sec_take;
    logic [CHW-1:0]   pick;
    logic             busy;

    assign busy = (state == ST_BUSY);

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        if (i == LINK) begin : g_link
            // The link slot has no channel state; its request pin is discarded.
            assign ch_req[i]  = 1'b0 & dreq[i];
            assign ch_last[i] = 1'b0;
            assign ch_addr[i] = '0;
        end else begin : g_real
            logic hit;
            assign hit = reg_wr && (reg_chan == CHW'(i));
            dma7_chan #(
                .AW  (AW),
                .CW  (CW),
                .WORD(chan_is_word(i, LINK))
            ) u_chan (
                .clk     (clk),
                .rst     (rst),
                .wr_addr (hit && (reg_sel == SEL_ADDR)),
                .wr_count(hit && (reg_sel == SEL_COUNT)),
                .wr_swreq(hit && (reg_sel == SEL_SWREQ)),
                .wr_data (reg_data),
                .hw_req  (dreq[i]),
                .step    (ch_step[i]),
                .req     (ch_req[i]),
                .out_addr(ch_addr[i]),
                .at_last (ch_last[i])
            );
        end
        assign ch_step[i] = busy && seq_done && (cur_ch == CHW'(i));
    end

    assign sec_req = ch_req[CH_N-1:LINK+1];
    assign pri_req = {sec_any, ch_req[LINK-1:0]};

    dma7_arb #(.N(SEC_N)) u_sec_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (sec_req),
        .rotate(rotate),
        .take  (sec_take),
        .any   (sec_any),
        .win   (sec_win)
    );

    dma7_arb #(.N(PRI_N)) u_pri_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (pri_req),
        .rotate(rotate),
        .take  (grant),
        .any   (pri_any),
        .win   (pri_win)
    );

    assign grant    = !busy && pri_any;
    assign sec_take = grant && (pri_win == LINK_SLOT);
    assign pick     = (pri_win == LINK_SLOT) ? CHW'(LINK + 1) + CHW'(sec_win)
                                             : CHW'(pri_win);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cur_ch <= '0;
            rotate <= 1'b0;
        end else begin
            if (reg_wr && reg_sel == SEL_MODE) begin
                rotate <= reg_data[0];
            end
            case (state)
                ST_IDLE: if (grant) begin
                    state  <= ST_BUSY;
                    cur_ch <= pick;
                end
                ST_BUSY: if (seq_done) begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign dack       = busy ? (CH_N'(1) << cur_ch) : '0;
    assign xfer_valid = busy;
    assign xfer_addr  = busy ? ch_addr[cur_ch] : '0;
    assign xfer_word  = busy && (int'(cur_ch) > LINK);
    assign xfer_tc    = busy && ch_last[cur_ch];

    // R8: never more than one acknowledge
    a_r8_dack_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    // R8: acknowledge holds until the sequencer finishes
    a_r8_dack_hold: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !seq_done) |=> ($stable(dack) && dack != '0));

    // R8: acknowledge drops right after done
    a_r8_dack_drop: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && seq_done) |=> (dack == '0));

    // R9: the link channel is never acknowledged
    a_r9_no_link_ack: assert property (@(posedge clk) disable iff (rst)
        !dack[LINK]);

    // R6: word transfers are word aligned
    a_r6_word_even: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && xfer_word) |-> !xfer_addr[0]);
endmodule

// File: tb/dma7_ctrl_test.sv
`timescale 1ns/1ps
module dma7_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [2:0]  reg_chan = '0;
    logic [26:0] reg_data = '0;
    logic [7:0]  dreq = '0;
    logic        seq_done = 1'b0;
    logic [7:0]  dack;
    logic        xfer_valid;
    logic [26:0] xfer_addr;
    logic        xfer_word;
    logic        xfer_tc;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dma7_ctrl uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_chan(reg_chan), .reg_data(reg_data), .dreq(dreq),
        .seq_done(seq_done), .dack(dack), .xfer_valid(xfer_valid),
        .xfer_addr(xfer_addr), .xfer_word(xfer_word), .xfer_tc(xfer_tc)
    );

    typedef struct packed {
        logic [2:0]  ch;
        logic [26:0] base;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{3'd0, 27'h0000010},
        '{3'd1, 27'h7FFFFFF},
        '{3'd2, 27'h0ABCDEF},
        '{3'd3, 27'h1000000},
        '{3'd5, 27'h0123456},
        '{3'd6, 27'h3FFFFFF},
        '{3'd7, 27'h5555555}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [2:0] c, input logic [26:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_chan = c; reg_data = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic serve(input int ch, input logic [26:0] ea, input logic ew,
                         input logic etc, input string tag);
        logic [7:0] held;
        int n = 0;
        while (dack == '0 && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " R8 grant channel"}, 32'(dack), 32'(8'd1 << ch));
        chk({tag, " address"}, 32'(xfer_addr), 32'(ea));
        chk({tag, " width"}, 32'(xfer_word), 32'(ew));
        chk({tag, " R7 terminal flag"}, 32'(xfer_tc), 32'(etc));
        held = dack;
        @(negedge clk);
        chk({tag, " R8 hold"}, 32'(dack), 32'(held));
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
        chk({tag, " R8 drop"}, 32'(dack), 32'h0);
    endtask

    task automatic quiet(input int cycles, input string tag);
        logic seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (dack != '0) seen = 1'b1;
        end
        chk(tag, 32'(seen), 32'h0);
    endtask

    function automatic logic [26:0] wbyte(input logic [26:0] w);
        return {w[25:0], 1'b0};
    endfunction

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 dack", 32'(dack), 32'h0);
        chk("R1 valid", 32'(xfer_valid), 32'h0);
        chk("R1 word", 32'(xfer_word), 32'h0);
        chk("R1 tc", 32'(xfer_tc), 32'h0);
        // R10 unprogrammed channels ignore requests
        dreq = 8'hEF;
        quiet(10, "R10 inert after reset");
        dreq = 8'h00;

        // Table: one terminal transfer per channel via software request
        for (int i = 0; i < 7; i++) begin
            logic w;
            w = (VECS[i].ch > 3'd4);
            wr(2'd0, VECS[i].ch, VECS[i].base);
            wr(2'd1, VECS[i].ch, 27'd0);
            wr(2'd2, VECS[i].ch, 27'd1);
            serve(int'(VECS[i].ch), w ? wbyte(VECS[i].base) : VECS[i].base, w, 1'b1,
                  w ? "R6 R4 table" : "R5 R4 table");
            quiet(6, "R4 R7 halted after table terminal");
        end

        // R2 fixed priority across both groups
        wr(2'd0, 3'd1, 27'h11); wr(2'd1, 3'd1, 27'd0);
        wr(2'd0, 3'd3, 27'h33); wr(2'd1, 3'd3, 27'd0);
        wr(2'd0, 3'd5, 27'h55); wr(2'd1, 3'd5, 27'd0);
        wr(2'd0, 3'd6, 27'h66); wr(2'd1, 3'd6, 27'd0);
        @(negedge clk);
        dreq = 8'b0110_1010;
        serve(1, 27'h11, 1'b0, 1'b1, "R2 fixed first");
        serve(3, 27'h33, 1'b0, 1'b1, "R2 fixed second");
        serve(5, wbyte(27'h55), 1'b1, 1'b1, "R2 fixed third");
        serve(6, wbyte(27'h66), 1'b1, 1'b1, "R2 fixed fourth");
        quiet(6, "R7 all halted after fixed run");
        dreq = 8'h00;

        // R3 rotating priority
        wr(2'd3, 3'd0, 27'd1);
        wr(2'd0, 3'd0, 27'h100); wr(2'd1, 3'd0, 27'd1);
        wr(2'd0, 3'd2, 27'h200); wr(2'd1, 3'd2, 27'd1);
        wr(2'd0, 3'd5, 27'h1000); wr(2'd1, 3'd5, 27'd1);
        wr(2'd0, 3'd7, 27'h2000); wr(2'd1, 3'd7, 27'd1);
        @(negedge clk);
        dreq = 8'b1010_0101;
        serve(0, 27'h100, 1'b0, 1'b0, "R3 rot 1");
        serve(2, 27'h200, 1'b0, 1'b0, "R3 rot 2");
        serve(7, wbyte(27'h2000), 1'b1, 1'b0, "R3 rot 3");
        serve(0, 27'h101, 1'b0, 1'b1, "R3 rot 4");
        serve(2, 27'h201, 1'b0, 1'b1, "R3 rot 5");
        serve(5, wbyte(27'h1000), 1'b1, 1'b0, "R3 rot 6");
        serve(7, wbyte(27'h2001), 1'b1, 1'b1, "R3 rot 7");
        serve(5, wbyte(27'h1001), 1'b1, 1'b1, "R3 rot 8");
        quiet(6, "R3 rot done");
        dreq = 8'h00;
        wr(2'd3, 3'd0, 27'd0);

        // R7 count stepping over several transfers
        wr(2'd0, 3'd3, 27'h50);
        wr(2'd1, 3'd3, 27'd2);
        wr(2'd2, 3'd3, 27'd1);
        serve(3, 27'h50, 1'b0, 1'b0, "R7 count 2");
        serve(3, 27'h51, 1'b0, 1'b0, "R7 count 1");
        serve(3, 27'h52, 1'b0, 1'b1, "R7 count 0");
        quiet(6, "R7 halted after count exhausted");
        // R4 software bit was cleared: re-arming alone gives no request
        wr(2'd1, 3'd3, 27'd0);
        quiet(6, "R4 software request cleared at terminal");
        @(negedge clk);
        dreq = 8'b0000_1000;
        serve(3, 27'h53, 1'b0, 1'b1, "R7 rearmed by count write");
        dreq = 8'h00;

        // R9 link channel ignores writes and its request line
        wr(2'd0, 3'd4, 27'h444);
        wr(2'd1, 3'd4, 27'd5);
        wr(2'd2, 3'd4, 27'd1);
        dreq = 8'b0001_0000;
        quiet(10, "R9 link channel never served");
        dreq = 8'h00;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule